// File: doc/BRIEF.md
# Prioritized Interrupt Arbitration Unit

This block picks the interrupt that a small 8-bit CPU core enters at an instruction boundary and supplies the address of that interrupt's vector. It takes four kinds of input:

- an active-low external interrupt pin;
- a timer request, which is the timer's flag already combined with its enable;
- a strobe that the core raises when it fetches a software-interrupt instruction;
- the core's global interrupt mask bit.

A sensitivity bit, driven from bit 3 of the system option register, selects how the pin is treated. With the bit at 0 the pin is edge-only. With the bit at 1 the pin is edge-and-level.

The core pulses a boundary strobe whenever it could take an interrupt. If a request qualifies, the unit pulses `take_o` one cycle later and presents the vector address on `vec_o`. It keeps both the chosen source and its vector until the core returns `ack_i`. When that acknowledge belongs to an external-pin entry, the external latch is cleared and `irq_clr_o` marks the clear. A new falling edge that arrives while the service routine runs is therefore captured and waits for the mask to drop.

Software interrupts ignore the mask. They are ordered against maskable requests by the moment of fetch: any enabled requests that were already pending at fetch go first, and anything that appears after fetch waits until the software interrupt has been entered.

Top module: `int_arbiter`

## Requirements
- R1: After reset `take_o` is 0, `vec_o` is 0x0000 and `irq_clr_o` is 0.
- R2: A falling edge on `irq_n_i` sets the external latch. With the mask clear, the next boundary takes it and `vec_o` = 0x3FFA.
- R3: A high `tmr_req_i` with the mask clear is taken at a boundary, with `vec_o` = 0x3FF8.
- R4: When the external and timer requests are both eligible, the external one is taken first. The timer follows at the next boundary after the acknowledge.
- R5: While `imask_i` is 1, neither the external request nor the timer request is taken. Once `imask_i` returns to 0, the next boundary takes the pending request.
- R6: A software-interrupt strobe is taken at the next boundary even while `imask_i` is 1, with `vec_o` = 0x3FFC.
- R7: An enabled maskable request that was already pending when `swi_i` pulsed is taken before the software interrupt.
- R8: A maskable request that appears after `swi_i` pulsed is taken only after the software interrupt.
- R9: With `irq_lvl_i` = 0 (edge only), a pin still held low after the latch is cleared raises no new request.
- R10: With `irq_lvl_i` = 1 (edge and level), a pin held low keeps the external request asserted after the latch is cleared.
- R11: `irq_clr_o` is 1 only during an `ack_i` cycle of an external-pin entry. A falling edge seen after that clear is latched and is taken once the mask clears.
- R12: From a grant until `ack_i`, `vec_o` holds its value and further boundary strobes are ignored.
- R13: `take_o` is a single-cycle pulse that appears exactly one cycle after the boundary strobe that granted it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_n_i | input | 1 | External interrupt pin, active low, asynchronous |
| irq_lvl_i | input | 1 | Pin sensitivity: 0 = edge only, 1 = edge and level |
| tmr_req_i | input | 1 | Timer interrupt request (flag combined with enable) |
| swi_i | input | 1 | Software-interrupt instruction fetch strobe |
| imask_i | input | 1 | Global interrupt mask bit |
| boundary_i | input | 1 | Instruction-boundary strobe |
| ack_i | input | 1 | Core acknowledges entry into the granted interrupt |
| take_o | output | 1 | Pulse: the core is to enter an interrupt |
| vec_o | output | 16 | Vector high-byte address of the granted source, 0 when idle |
| irq_clr_o | output | 1 | External latch is being cleared this cycle |

## Verification
A wrong grant register shows up on `vec_o` in the cycle after the boundary strobe, where it appears as the wrong address or as a change before the acknowledge. A stuck external latch, or one that is never set, becomes visible at the first boundary after the acknowledge. In that case a second entry appears when none is due, or an expected entry is missing. A bad fetch-time snapshot leaves its trace only in the order of two consecutive entries, so each ordering scenario runs both entries and compares the sequence of vectors.

// File: rtl/int_arb_pkg.sv
package int_arb_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_SWI  = 2'd1,
    SRC_IRQ  = 2'd2,
    SRC_TMR  = 2'd3
  } src_e;

  // maskable request vector layout: index 1 = pin, index 0 = timer
  localparam int unsigned REQ_W   = 2;
  localparam int unsigned REQ_IRQ = 1;
  localparam int unsigned REQ_TMR = 0;
endpackage

// File: rtl/int_arb_irq_front.sv
module int_arb_irq_front #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic irq_n_i,
  input  logic lvl_en_i,
  input  logic clr_i,
  output logic req_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   pin_q;
  logic                   prev_q;
  logic                   latch_q;
  logic                   fall;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= irq_n_i;
      end
    end else begin : g_syncn
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], irq_n_i};
      end
    end
  endgenerate

  assign pin_q = sync_q[SYNC_STAGES-1];
  assign fall  = prev_q & ~pin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b1;
      latch_q <= 1'b0;
    end else begin
      prev_q <= pin_q;
      // a new edge wins over a clear in the same cycle
      if (fall)       latch_q <= 1'b1;
      else if (clr_i) latch_q <= 1'b0;
    end
  end

  assign req_o = latch_q | (lvl_en_i & ~pin_q);
endmodule

// File: rtl/int_arb_core.sv
module int_arb_core
  import int_arb_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic boundary_i,
  input  logic ack_i,
  input  logic swi_i,
  input  logic imask_i,
  input  logic irq_req_i,
  input  logic tmr_req_i,
  output logic take_o,
  output src_e src_o,
  output logic clr_irq_o
);
  logic [REQ_W-1:0] req, elig, cand, gmask, snap_q;
  logic             swi_pend_q, busy_q, take_q, grant;
  src_e             win, src_q;

  always_comb begin
    req          = '0;
    req[REQ_IRQ] = irq_req_i;
    req[REQ_TMR] = tmr_req_i;
  end

  assign elig = req & {REQ_W{~imask_i}};
  // requests that predate a fetched software interrupt
  assign cand = swi_pend_q ? (snap_q & elig) : elig;

  always_comb begin
    if (cand[REQ_IRQ])      win = SRC_IRQ;
    else if (cand[REQ_TMR]) win = SRC_TMR;
    else if (swi_pend_q)    win = SRC_SWI;
    else                    win = SRC_NONE;
  end

  assign grant = boundary_i & ~busy_q & (win != SRC_NONE);

  always_comb begin
    gmask = '0;
    if (grant && win == SRC_IRQ) gmask[REQ_IRQ] = 1'b1;
    if (grant && win == SRC_TMR) gmask[REQ_TMR] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      src_q  <= SRC_NONE;
      take_q <= 1'b0;
    end else begin
      take_q <= grant;
      if (grant) begin
        busy_q <= 1'b1;
        src_q  <= win;
      end else if (ack_i && busy_q) begin
        busy_q <= 1'b0;
        src_q  <= SRC_NONE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      swi_pend_q <= 1'b0;
      snap_q     <= '0;
    end else if (grant && win == SRC_SWI) begin
      swi_pend_q <= 1'b0;
      snap_q     <= '0;
    end else if (swi_i && !swi_pend_q) begin
      swi_pend_q <= 1'b1;
      snap_q     <= elig;
    end else begin
      snap_q <= snap_q & ~gmask & req;
    end
  end

  assign take_o    = take_q;
  assign src_o     = src_q;
  assign clr_irq_o = ack_i & busy_q & (src_q == SRC_IRQ);
endmodule

// File: rtl/int_arb_vec.sv
module int_arb_vec
  import int_arb_pkg::*;
#(
  parameter logic [15:0] VEC_TOP  = 16'h3FFC,
  parameter logic [15:0] VEC_STEP = 16'h0002
) (
  input  src_e        src_i,
  output logic [15:0] vec_o
);
  localparam logic [15:0] VEC_IRQ = VEC_TOP - VEC_STEP;
  localparam logic [15:0] VEC_TMR = VEC_TOP - 16'(2 * VEC_STEP);

  always_comb begin
    unique case (src_i)
      SRC_SWI: vec_o = VEC_TOP;
      SRC_IRQ: vec_o = VEC_IRQ;
      SRC_TMR: vec_o = VEC_TMR;
      default: vec_o = 16'h0000;
    endcase
  end
endmodule

// File: rtl/int_arbiter.sv
module int_arbiter
  import int_arb_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [15:0] VEC_SWI     = 16'h3FFC,
  parameter logic [15:0] VEC_STEP    = 16'h0002
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        irq_n_i,
  input  logic        irq_lvl_i,
  input  logic        tmr_req_i,
  input  logic        swi_i,
  input  logic        imask_i,
  input  logic        boundary_i,
  input  logic        ack_i,
  output logic        take_o,
  output logic [15:0] vec_o,
  output logic        irq_clr_o
);
  logic irq_req, clr_irq;
  src_e src;

  int_arb_irq_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .irq_n_i  (irq_n_i),
    .lvl_en_i (irq_lvl_i),
    .clr_i    (clr_irq),
    .req_o    (irq_req)
  );

  int_arb_core u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .boundary_i (boundary_i),
    .ack_i      (ack_i),
    .swi_i      (swi_i),
    .imask_i    (imask_i),
    .irq_req_i  (irq_req),
    .tmr_req_i  (tmr_req_i),
    .take_o     (take_o),
    .src_o      (src),
    .clr_irq_o  (clr_irq)
  );

  int_arb_vec #(.VEC_TOP(VEC_SWI), .VEC_STEP(VEC_STEP)) u_vec (
    .src_i (src),
    .vec_o (vec_o)
  );

  assign irq_clr_o = clr_irq;
endmodule

// File: rtl/int_arbiter_chk.sv
module int_arbiter_chk #(
  parameter logic [15:0] VEC_SWI  = 16'h3FFC,
  parameter logic [15:0] VEC_STEP = 16'h0002
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        boundary_i,
  input logic        ack_i,
  input logic        imask_i,
  input logic        take_o,
  input logic [15:0] vec_o,
  input logic        irq_clr_o
);
  localparam logic [15:0] VEC_IRQ = VEC_SWI - VEC_STEP;

  assert_take_after_boundary_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> $past(boundary_i));

  assert_take_single_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> !take_o);

  assert_vec_held_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_o != 16'h0000 && !ack_i) |=> $stable(vec_o));

  assert_masked_only_swi_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && $past(imask_i)) |-> vec_o == VEC_SWI);

  assert_clr_on_ack_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_clr_o |-> (ack_i && vec_o == VEC_IRQ));

  assert_take_has_vec_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> vec_o != 16'h0000);
endmodule

bind int_arbiter int_arbiter_chk #(.VEC_SWI(VEC_SWI), .VEC_STEP(VEC_STEP)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .boundary_i (boundary_i),
  .ack_i      (ack_i),
  .imask_i    (imask_i),
  .take_o     (take_o),
  .vec_o      (vec_o),
  .irq_clr_o  (irq_clr_o)
);

// File: tb/sim_int_arbiter.sv
`timescale 1ns/1ps
module sim_int_arbiter;
  localparam logic [15:0] V_SWI = 16'h3FFC;
  localparam logic [15:0] V_IRQ = 16'h3FFA;
  localparam logic [15:0] V_TMR = 16'h3FF8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic irq_n = 1'b1, lvl = 1'b0, tmr = 1'b0, swi = 1'b0, imask = 1'b0;
  logic bnd = 1'b0, ack = 1'b0;
  logic take, clr;
  logic [15:0] vec;
  int total = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  int_arbiter u0 (
    .clk_i(clk), .rst_ni(rst_n), .irq_n_i(irq_n), .irq_lvl_i(lvl),
    .tmr_req_i(tmr), .swi_i(swi), .imask_i(imask), .boundary_i(bnd),
    .ack_i(ack), .take_o(take), .vec_o(vec), .irq_clr_o(clr)
  );

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // boundary strobe; take/vec checked the cycle after
  task automatic boundary(string req, bit exp_take, logic [15:0] exp_vec);
    bnd = 1'b1; tick(); bnd = 1'b0;
    chk(req, {31'd0, take}, {31'd0, exp_take});
    chk(req, {16'd0, vec}, {16'd0, exp_vec});
  endtask

  task automatic acknowledge(string req, bit exp_clr);
    ack = 1'b1; #0.5;
    chk(req, {31'd0, clr}, {31'd0, exp_clr});
    tick(); ack = 1'b0;
  endtask

  task automatic pin_fall();
    irq_n = 1'b0; tick(5);
  endtask

  task automatic pin_rise();
    irq_n = 1'b1; tick(5);
  endtask

  task automatic t_reset();
    chk("R1 take", {31'd0, take}, 32'd0);
    chk("R1 vec", {16'd0, vec}, 32'd0);
    chk("R1 clr", {31'd0, clr}, 32'd0);
  endtask

  task automatic t_irq_edge();
    pin_fall(); pin_rise();
    boundary("R2 pin edge", 1'b1, V_IRQ);
    acknowledge("R11 clr on pin entry", 1'b1);
    boundary("R2 latch cleared", 1'b0, 16'h0000);
  endtask

  task automatic t_timer();
    tmr = 1'b1; tick();
    boundary("R3 timer", 1'b1, V_TMR);
    acknowledge("R11 no clr on timer", 1'b0);
    tmr = 1'b0; tick();
  endtask

  task automatic t_priority();
    tmr = 1'b1; pin_fall(); pin_rise();
    boundary("R4 pin first", 1'b1, V_IRQ);
    acknowledge("R4 ack", 1'b1);
    boundary("R4 timer second", 1'b1, V_TMR);
    acknowledge("R4 ack2", 1'b0);
    tmr = 1'b0; tick();
  endtask

  task automatic t_mask();
    imask = 1'b1; tmr = 1'b1; pin_fall(); pin_rise();
    boundary("R5 masked", 1'b0, 16'h0000);
    imask = 1'b0; tick();
    boundary("R5 unmasked pin", 1'b1, V_IRQ);
    acknowledge("R5 ack", 1'b1);
    boundary("R5 unmasked timer", 1'b1, V_TMR);
    acknowledge("R5 ack2", 1'b0);
    tmr = 1'b0; tick();
  endtask

  task automatic t_swi_masked();
    imask = 1'b1; tmr = 1'b1;
    swi = 1'b1; tick(); swi = 1'b0;
    boundary("R6 swi while masked", 1'b1, V_SWI);
    acknowledge("R6 ack", 1'b0);
    boundary("R6 swi consumed", 1'b0, 16'h0000);
    tmr = 1'b0; imask = 1'b0; tick();
  endtask

  task automatic t_swi_after_pending();
    tmr = 1'b1; tick();
    swi = 1'b1; tick(); swi = 1'b0;
    boundary("R7 pending first", 1'b1, V_TMR);
    acknowledge("R7 ack", 1'b0);
    imask = 1'b1;
    boundary("R7 swi next", 1'b1, V_SWI);
    acknowledge("R7 ack2", 1'b0);
    tmr = 1'b0; imask = 1'b0; tick();
  endtask

  task automatic t_swi_before_new();
    swi = 1'b1; tick(); swi = 1'b0;
    tmr = 1'b1; pin_fall(); pin_rise();
    boundary("R8 swi before new", 1'b1, V_SWI);
    acknowledge("R8 ack", 1'b0);
    boundary("R8 new pin after", 1'b1, V_IRQ);
    acknowledge("R8 ack2", 1'b1);
    boundary("R8 new timer after", 1'b1, V_TMR);
    acknowledge("R8 ack3", 1'b0);
    tmr = 1'b0; tick();
  endtask

  task automatic t_edge_only_low();
    lvl = 1'b0; pin_fall();
    boundary("R9 edge", 1'b1, V_IRQ);
    acknowledge("R9 ack", 1'b1);
    tick(2);
    boundary("R9 held low ignored", 1'b0, 16'h0000);
    pin_rise();
  endtask

  task automatic t_level_low();
    lvl = 1'b1; pin_fall();
    boundary("R10 edge", 1'b1, V_IRQ);
    acknowledge("R10 ack", 1'b1);
    tick(2);
    boundary("R10 level retake", 1'b1, V_IRQ);
    acknowledge("R10 ack2", 1'b1);
    pin_rise(); lvl = 1'b0; tick();
    boundary("R10 released", 1'b0, 16'h0000);
  endtask

  task automatic t_pulse_during_service();
    pin_fall(); pin_rise();
    boundary("R11 first", 1'b1, V_IRQ);
    acknowledge("R11 clr", 1'b1);
    imask = 1'b1;
    pin_fall(); pin_rise();
    boundary("R11 held while masked", 1'b0, 16'h0000);
    imask = 1'b0; tick();
    boundary("R11 retaken", 1'b1, V_IRQ);
    acknowledge("R11 clr2", 1'b1);
    boundary("R11 single capture", 1'b0, 16'h0000);
  endtask

  task automatic t_hold();
    tmr = 1'b1; tick();
    boundary("R13 take", 1'b1, V_TMR);
    tick();
    chk("R13 take one cycle", {31'd0, take}, 32'd0);
    pin_fall(); pin_rise();
    boundary("R12 boundary ignored", 1'b0, V_TMR);
    tick(3);
    chk("R12 vec held", {16'd0, vec}, {16'd0, V_TMR});
    acknowledge("R12 ack", 1'b0);
    chk("R12 idle after ack", {16'd0, vec}, 32'd0);
    boundary("R12 pin after", 1'b1, V_IRQ);
    acknowledge("R12 ack2", 1'b1);
    tmr = 1'b0; tick();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    tick(3);
    t_reset();
    rst_n = 1'b1; tick(2);
    t_irq_edge();
    t_timer();
    t_priority();
    t_mask();
    t_swi_masked();
    t_swi_after_pending();
    t_swi_before_new();
    t_edge_only_low();
    t_level_low();
    t_pulse_during_service();
    t_hold();
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule